// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Aggregator

This block gathers the interrupt sources of two IDE channels and presents them to a host through a small byte-wide register window. Each channel has two sources: a drive interrupt and a bus-master completion interrupt. Each source is latched into a pending bit. A per-channel mask gates the pending bits, and a per-channel polarity bit shapes that channel's host interrupt line.

The register window also holds a chip-mode setting with two fields, legacy-compatible versus native and test versus normal. A write to the mode register takes effect only when a key bit in the written byte is set. A strap input reports whether a legacy header is fitted.

Channel 0 status is read at the mode offset. Channel 1 status is read beside the mask bits. Pending bits are acknowledged through a separate write-one-to-clear register, so writes to the mode and mask registers never disturb status. Reads have no side effects and return data combinationally for the presented address.

Top module: `irqAgg`

## Requirements
- R1: After reset all pending bits, both mask bits, both polarity bits and both mode outputs are 0, both host interrupt lines are 0, and offset 3 reads back only the strap in bit 4.
- R2: A write to offset 2 with bit 7 set loads modeLegacy from bit 1 and modeTest from bit 0. A write to offset 2 with bit 7 clear leaves both mode outputs unchanged.
- R3: A read of offset 2 returns the channel-0 bus-master pending bit in bit 1 and the channel-0 drive pending bit in bit 0. Bits 7 to 2 read as 0.
- R4: At offset 3, bits 1:0 are the channel-1 and channel-0 mask bits (bit 0 is channel 0, bit 1 is channel 1) and are loaded by a write. Bit 2 reads the channel-1 drive pending bit, bit 3 reads the channel-1 bus-master pending bit, bit 4 reads legacyHdr, and bits 7:5 read 0. Writes to bits 4:2 have no effect.
- R5: A drive pending bit is set at the first clock edge that samples its drvIrq line high after it was low. It is cleared at any edge that samples the line low. It is not set again while the line stays high.
- R6: A one-cycle pulse on bmDone sets that channel's bus-master pending bit. The bit holds until it is acknowledged.
- R7: A write to offset 0 clears each pending bit whose position holds a 1: bit 0 is channel-0 drive, bit 1 is channel-0 bus-master, bit 2 is channel-1 drive, bit 3 is channel-1 bus-master. Positions written 0 are unchanged. A read of offset 0 returns these four bits, with bits 7:4 reading 0.
- R8: When a set event and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R9: hostIrq[c] is the OR of channel c's unmasked pending bits, inverted when the channel's polarity bit is 1 (active-low). Offset 1 bits 1:0 hold the polarity bits, are loaded by a write and read back, with bits 7:2 reading 0.
- R10: Masking a channel does not stop its sources from being latched. Masked pending bits stay visible in the status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Register write strobe, one cycle per write |
| hostAddr | input | 2 | Register offset |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data for hostAddr, combinational |
| drvIrq | input | 2 | Drive interrupt level, one bit per channel |
| bmDone | input | 2 | Bus-master completion pulse, one bit per channel |
| legacyHdr | input | 1 | Strap: legacy header present |
| hostIrq | output | 2 | Host interrupt line per channel, polarity applied |
| modeLegacy | output | 1 | 1 = legacy-compatible mode, 0 = native mode |
| modeTest | output | 1 | 1 = test mode, 0 = normal mode |

## Verification
The assertions assume that hostWr, hostAddr, hostWdata, drvIrq and bmDone are synchronous to clk. They also assume that bmDone is a clean pulse that never needs to be counted twice, since a long pulse simply re-sets its bit every cycle. The bench drives every input on the falling edge and holds each bmDone pulse for exactly one cycle. It samples outputs one nanosecond after that falling edge, so every input is stable across the rising edge that captures it. Deliberate same-cycle collisions of a set and an acknowledge are staged only to exercise the set-wins rule.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int ACK_W  = 2 * NUM_CH;
  localparam int KEY_BIT = 7;

  typedef logic [ADDR_W-1:0] regAddr_t;

  localparam regAddr_t OFF_ACK  = 2'd0;
  localparam regAddr_t OFF_POL  = 2'd1;
  localparam regAddr_t OFF_MODE = 2'd2;
  localparam regAddr_t OFF_MASK = 2'd3;

  typedef struct packed {
    logic ackWr;
    logic polWr;
    logic modeWr;
    logic maskWr;
  } regStrobe_t;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
(
  input  logic       hostWr,
  input  regAddr_t   hostAddr,
  input  logic       keyBit,
  output regStrobe_t stb
);
  always_comb begin
    stb = '0;
    if (hostWr) begin
      unique case (hostAddr)
        OFF_ACK:  stb.ackWr  = 1'b1;
        OFF_POL:  stb.polWr  = 1'b1;
        OFF_MODE: stb.modeWr = keyBit;
        OFF_MASK: stb.maskWr = 1'b1;
        default:  stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqAggDp.sv
module irqAggDp
  import irqAggPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [ACK_W-1:0]   wNib,
  input  logic [NUM_CH-1:0]  drvIrq,
  input  logic [NUM_CH-1:0]  bmDone,
  input  logic               legacyHdr,
  input  regAddr_t           rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CH-1:0]  hostIrq,
  output logic [ACK_W-1:0]   pendVec,
  output logic [NUM_CH-1:0]  maskQ,
  output logic [NUM_CH-1:0]  polQ,
  output logic               modeLegacy,
  output logic               modeTest
);
  // Per-channel status latches and output shaping
  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic drvPrev, drvPend, bmPend;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        drvPrev <= 1'b0;
        drvPend <= 1'b0;
        bmPend  <= 1'b0;
      end else begin
        drvPrev <= drvIrq[c];
        if (drvIrq[c] && !drvPrev)
          drvPend <= 1'b1;
        else if (!drvIrq[c])
          drvPend <= 1'b0;
        else if (stb.ackWr && wNib[2*c])
          drvPend <= 1'b0;

        if (bmDone[c])
          bmPend <= 1'b1;
        else if (stb.ackWr && wNib[2*c+1])
          bmPend <= 1'b0;
      end
    end

    assign pendVec[2*c]   = drvPend;
    assign pendVec[2*c+1] = bmPend;
    assign hostIrq[c] = ((drvPend | bmPend) & ~maskQ[c]) ^ polQ[c];
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ      <= '0;
      polQ       <= '0;
      modeLegacy <= 1'b0;
      modeTest   <= 1'b0;
    end else begin
      if (stb.maskWr) maskQ <= wNib[NUM_CH-1:0];
      if (stb.polWr)  polQ  <= wNib[NUM_CH-1:0];
      if (stb.modeWr) begin
        modeLegacy <= wNib[1];
        modeTest   <= wNib[0];
      end
    end
  end

  // Side-effect-free read mux
  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      OFF_ACK:  rdData[ACK_W-1:0]  = pendVec;
      OFF_POL:  rdData[NUM_CH-1:0] = polQ;
      OFF_MODE: rdData[1:0]        = pendVec[1:0];
      OFF_MASK: rdData[4:0]        = {legacyHdr, pendVec[3], pendVec[2], maskQ};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqAgg.sv
module irqAgg
  import irqAggPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic [1:0]        drvIrq,
  input  logic [1:0]        bmDone,
  input  logic              legacyHdr,
  output logic [1:0]        hostIrq,
  output logic              modeLegacy,
  output logic              modeTest
);
  regStrobe_t         stb;
  logic [ACK_W-1:0]   pendVec;
  logic [NUM_CH-1:0]  maskQ;
  logic [NUM_CH-1:0]  polQ;
  logic               unusedWdata;

  assign unusedWdata = ^hostWdata[6:4];

  irqAggCtrl uCtrl (
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .keyBit   (hostWdata[KEY_BIT]),
    .stb      (stb)
  );

  irqAggDp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wNib       (hostWdata[ACK_W-1:0]),
    .drvIrq     (drvIrq),
    .bmDone     (bmDone),
    .legacyHdr  (legacyHdr),
    .rdAddr     (hostAddr),
    .rdData     (hostRdata),
    .hostIrq    (hostIrq),
    .pendVec    (pendVec),
    .maskQ      (maskQ),
    .polQ       (polQ),
    .modeLegacy (modeLegacy),
    .modeTest   (modeTest)
  );
endmodule

// File: rtl/irqAggChk.sv
module irqAggChk
  import irqAggPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic [1:0]        hostAddr,
  input logic [7:0]        hostWdata,
  input logic [1:0]        drvIrq,
  input logic [1:0]        bmDone,
  input logic [1:0]        hostIrq,
  input logic              modeLegacy,
  input logic              modeTest,
  input logic [ACK_W-1:0]  pendVec,
  input logic [NUM_CH-1:0] maskQ,
  input logic [NUM_CH-1:0] polQ
);
  // R6
  bm_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    bmDone[0] |=> pendVec[1]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bmDone[1] && hostWr && hostAddr == OFF_ACK && hostWdata[3]) |=> pendVec[3]);

  // R5
  drv_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !drvIrq[0] |=> !pendVec[0]);

  // R2
  mode_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == OFF_MODE && !hostWdata[KEY_BIT]) |=> $stable({modeLegacy, modeTest}));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == OFF_ACK && hostWdata[1] && !bmDone[0]) |=> !pendVec[1]);

  // R9
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[0] && !polQ[0]) |-> !hostIrq[0]);
endmodule

bind irqAgg irqAggChk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWr     (hostWr),
  .hostAddr   (hostAddr),
  .hostWdata  (hostWdata),
  .drvIrq     (drvIrq),
  .bmDone     (bmDone),
  .hostIrq    (hostIrq),
  .modeLegacy (modeLegacy),
  .modeTest   (modeTest),
  .pendVec    (pendVec),
  .maskQ      (maskQ),
  .polQ       (polQ)
);

// File: tb/tb_irqAgg.sv
`timescale 1ns/1ps
module tb_irqAgg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWdata = 8'd0;
  logic [7:0] hostRdata;
  logic [1:0] drvIrq = 2'b00;
  logic [1:0] bmDone = 2'b00;
  logic       legacyHdr = 1'b1;
  logic [1:0] hostIrq;
  logic       modeLegacy, modeTest;

  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  irqAgg dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .drvIrq(drvIrq),
    .bmDone(bmDone), .legacyHdr(legacyHdr), .hostIrq(hostIrq),
    .modeLegacy(modeLegacy), .modeTest(modeTest)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0; hostWdata = 8'd0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic pulseBm(input int ch);
    @(negedge clk);
    bmDone[ch] = 1'b1;
    @(negedge clk);
    bmDone[ch] = 1'b0;
  endtask

  task automatic setDrv(input int ch, input logic v);
    @(negedge clk);
    drvIrq[ch] = v;
    @(negedge clk);
  endtask

  task automatic testReset;
    logic [7:0] r;
    rdReg(2'd0, r); chk("R1 ack reg", r, 8'h00);
    rdReg(2'd1, r); chk("R1 pol reg", r, 8'h00);
    rdReg(2'd2, r); chk("R1 mode/status reg", r, 8'h00);
    rdReg(2'd3, r); chk("R1 mask reg", r, 8'h10);
    chk("R1 hostIrq", {6'd0, hostIrq}, 8'h00);
    chk("R1 modes", {6'd0, modeLegacy, modeTest}, 8'h00);
  endtask

  task automatic testMode;
    wrReg(2'd2, 8'h03);
    chk("R2 keyless write ignored", {6'd0, modeLegacy, modeTest}, 8'h00);
    wrReg(2'd2, 8'h83);
    chk("R2 keyed write 0x83", {6'd0, modeLegacy, modeTest}, 8'h03);
    wrReg(2'd2, 8'h81);
    chk("R2 keyed write 0x81", {6'd0, modeLegacy, modeTest}, 8'h01);
    wrReg(2'd2, 8'h02);
    chk("R2 keyless write 0x02 ignored", {6'd0, modeLegacy, modeTest}, 8'h01);
  endtask

  task automatic testBm;
    logic [7:0] r;
    pulseBm(0);
    rdReg(2'd2, r); chk("R3 ch0 bm status at offset 2", r, 8'h02);
    rdReg(2'd0, r); chk("R6 ch0 bm pending at offset 0", r, 8'h02);
    chk("R9 hostIrq0 active-high", {7'd0, hostIrq[0]}, 8'h01);
    wrReg(2'd0, 8'h01);
    rdReg(2'd0, r); chk("R7 zero position keeps bm0", r, 8'h02);
    wrReg(2'd0, 8'h02);
    rdReg(2'd2, r); chk("R7 bm0 acknowledged", r, 8'h00);
    chk("R9 hostIrq0 idle", {7'd0, hostIrq[0]}, 8'h00);
  endtask

  task automatic testDrv;
    logic [7:0] r;
    setDrv(1, 1'b1);
    rdReg(2'd3, r); chk("R5 ch1 drive set on rise", r, 8'h14);
    wrReg(2'd3, 8'hFC);
    rdReg(2'd3, r); chk("R4 write to status bits ignored", r, 8'h14);
    wrReg(2'd0, 8'h04);
    rdReg(2'd3, r); chk("R7 ch1 drive acknowledged", r, 8'h10);
    rdReg(2'd3, r); chk("R5 no re-set while high", r, 8'h10);
    setDrv(1, 1'b0);
    setDrv(1, 1'b1);
    rdReg(2'd3, r); chk("R5 second rise sets", r, 8'h14);
    setDrv(1, 1'b0);
    rdReg(2'd3, r); chk("R5 low clears", r, 8'h10);
    setDrv(0, 1'b1);
    rdReg(2'd2, r); chk("R3 ch0 drive status bit0", r, 8'h01);
    setDrv(0, 1'b0);
    rdReg(2'd2, r); chk("R5 ch0 drive cleared", r, 8'h00);
  endtask

  task automatic testMaskPol;
    logic [7:0] r;
    pulseBm(1);
    chk("R9 hostIrq1 raised", {6'd0, hostIrq}, 8'h02);
    wrReg(2'd3, 8'h02);
    chk("R9 hostIrq1 masked", {6'd0, hostIrq}, 8'h00);
    rdReg(2'd3, r); chk("R4 mask bit1 and bm1 status", r, 8'h1A);
    wrReg(2'd1, 8'h02);
    rdReg(2'd1, r); chk("R9 polarity readback", r, 8'h02);
    chk("R9 masked active-low idles high", {6'd0, hostIrq}, 8'h02);
    wrReg(2'd3, 8'h00);
    chk("R9 unmasked active-low asserts low", {6'd0, hostIrq}, 8'h00);
    wrReg(2'd0, 8'h08);
    chk("R9 active-low idle after ack", {6'd0, hostIrq}, 8'h02);
    wrReg(2'd1, 8'h00);
    chk("R9 polarity restored", {6'd0, hostIrq}, 8'h00);
    wrReg(2'd3, 8'h01);
    pulseBm(0);
    rdReg(2'd2, r); chk("R10 masked ch0 still latched", r, 8'h02);
    chk("R10 masked ch0 no interrupt", {6'd0, hostIrq}, 8'h00);
    wrReg(2'd0, 8'h02);
    wrReg(2'd3, 8'h00);
  endtask

  task automatic testSetWins;
    logic [7:0] r;
    pulseBm(1);
    @(negedge clk);
    bmDone[1] = 1'b1;
    hostWr = 1'b1; hostAddr = 2'd0; hostWdata = 8'h08;
    @(negedge clk);
    bmDone[1] = 1'b0; hostWr = 1'b0; hostWdata = 8'h00;
    rdReg(2'd0, r); chk("R8 set beats same-cycle ack", r, 8'h08);
    wrReg(2'd0, 8'h08);
    rdReg(2'd0, r); chk("R7 later ack clears", r, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMode();
    testBm();
    testDrv();
    testMaskPol();
    testSetWins();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule